// File: doc/BRIEF.md
# Adaptive Supply Rail Selector

This block sits beside a headphone or line amplifier. It watches the digital audio samples on their way to the amplifier and picks the supply level that a charge pump should deliver: full rails or half rails. A 2-bit mode input chooses between two behaviours. In the adaptive mode the choice follows the signal level. In every other mode the choice is a fixed level given on a separate input.

In the adaptive mode, any sample whose magnitude could not be reproduced on half rails forces full rails at the next rail-switch clock enable. The block returns to half rails only after a hold window of `SW_RATE_HZ` enable pulses, which is one second of the switching clock, passes with no such sample. Each loud sample restarts the window. This hysteresis keeps the rails from toggling when a signal hovers near the threshold, and it keeps the rails up through bursts of transients.

The controller is a three-state machine. `ST_FIXED` drives the externally selected level. `ST_AD_HI` drives full rails while the hold window counts down. `ST_AD_LO` drives half rails. The transitions, all taken only on a `sw_en` pulse, are:

- **leave-adaptive**: any state goes to `ST_FIXED` when the mode is not 11.
- **enter-adaptive**: `ST_FIXED` goes to `ST_AD_HI` with the window reloaded.
- **retrigger**: `ST_AD_HI` stays in `ST_AD_HI` and reloads the window on a loud sample.
- **expire**: `ST_AD_HI` goes to `ST_AD_LO` when the last count is used up.
- **boost**: `ST_AD_LO` goes to `ST_AD_HI` on a loud sample.

Top module: `rail_sel_ctrl`

## Requirements
- R1: After reset, `rail_hi` is 1 and the hold window is full. With mode 11 and no loud sample, `rail_hi` falls at the `SW_RATE_HZ`-th `sw_en` pulse after reset.
- R2: When `mode` is not 2'b11 at a `sw_en` pulse, `rail_hi` after that pulse equals `fixed_hi` as sampled on the pulse, and sample levels have no effect.
- R3: A sample is loud when `smp_data`, read as W-bit two's complement, has a magnitude strictly greater than `CLIP_LVL`. A magnitude equal to `CLIP_LVL` is not loud. The code -2^(W-1) is loud.
- R4: With mode 11, if a loud sample arrived since the previous `sw_en` pulse (the pulse cycle included), `rail_hi` is 1 after the pulse.
- R5: With mode 11, `rail_hi` falls at the `SW_RATE_HZ`-th `sw_en` pulse after the pulse that last saw a loud sample, provided no loud sample arrives in between.
- R6: A loud sample inside the hold window restarts the window at its full length, so loud samples spaced closer than the window keep `rail_hi` at 1.
- R7: `rail_hi` changes only in the cycle that follows a `sw_en` pulse.
- R8: Sample data presented while `smp_valid` is 0 is ignored.
- R9: When mode 11 starts after a fixed mode, `rail_hi` is 1 after the first `sw_en` pulse, and the full hold window runs before it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | 2'b11 selects adaptive mode; any other value selects fixed mode |
| fixed_hi | input | 1 | Rail level used in fixed mode (1 = full rails) |
| smp_valid | input | 1 | Strobe that qualifies `smp_data` |
| smp_data | input | W | Signed audio sample going to the amplifier |
| sw_en | input | 1 | One-cycle enable at the rail-switch clock rate |
| rail_hi | output | 1 | Registered rail request: 1 = full rails, 0 = half rails |

## Verification
The bench builds the block with W=8, CLIP_LVL=64 and SW_RATE_HZ=5, and pulses `sw_en` every fourth clock. The short window lets the bench run several complete expire and retrigger cycles, and reach the exact pulse on which the rails drop, within a few hundred clocks. With 8-bit samples, the threshold edges (±64, 65) and the most negative code -128 are easy to drive directly. A behavioural model compares `rail_hi` on every cycle, so any change between enable pulses is caught.

// File: rtl/rail_pkg.sv
package rail_pkg;
    typedef enum logic [1:0] {
        ST_FIXED = 2'd0,
        ST_AD_HI = 2'd1,
        ST_AD_LO = 2'd2
    } rail_state_e;

    localparam logic [1:0] MODE_ADAPT = 2'b11;
endpackage

// File: rtl/rail_hit_acc.sv
module rail_hit_acc #(
    parameter int W        = 16,
    parameter int CLIP_LVL = 2 ** (W - 2)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_valid,
    input  logic [W-1:0] smp_data,
    input  logic         sw_en,
    output logic         hit
);
    localparam logic [W-1:0] THR = W'(CLIP_LVL);

    logic [W-1:0] mag;
    logic         loud_now;
    logic         pend_q;

    // Negating the most negative code gives 2^(W-1), which is correct as an unsigned value.
    always_comb begin
        mag      = smp_data[W-1] ? (~smp_data + W'(1)) : smp_data;
        loud_now = smp_valid && (mag > THR);
        hit      = pend_q || loud_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (sw_en)    pend_q <= 1'b0;
        else if (loud_now) pend_q <= 1'b1;
    end

    // R8: an unqualified sample never raises the pending flag
    p_invalid_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid && !sw_en && !pend_q) |=> !pend_q);
    // R3: the most negative code always counts as loud
    p_neg_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_data == {1'b1, {(W-1){1'b0}}}) |-> hit);
endmodule

// File: rtl/rail_hold_tmr.sv
module rail_hold_tmr #(
    parameter int HOLD_TICKS = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic dec,
    input  logic clr,
    output logic last
);
    localparam int             CW   = $clog2(HOLD_TICKS + 1);
    localparam logic [CW-1:0]  FULL = CW'(HOLD_TICKS);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt_q <= FULL;
        else if (clr)                   cnt_q <= '0;
        else if (load)                  cnt_q <= FULL;
        else if (dec && cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
    end

    assign last = (cnt_q == CW'(1));

    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL);
    // R6: a reload restores the full window
    p_reload_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clr) |=> cnt_q == FULL);
endmodule

// File: rtl/rail_sel_ctrl.sv
module rail_sel_ctrl
    import rail_pkg::*;
#(
    parameter int W          = 16,
    parameter int CLIP_LVL   = 2 ** (W - 2),
    parameter int SW_RATE_HZ = 1000000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode,
    input  logic         fixed_hi,
    input  logic         smp_valid,
    input  logic [W-1:0] smp_data,
    input  logic         sw_en,
    output logic         rail_hi
);
    localparam int HOLD_TICKS = SW_RATE_HZ;

    rail_state_e state_q, state_d;
    logic        hit, last;
    logic        t_load, t_dec, t_clr;
    logic        adapt;

    assign adapt = (mode == MODE_ADAPT);

    rail_hit_acc #(.W(W), .CLIP_LVL(CLIP_LVL)) u_hit (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_valid(smp_valid),
        .smp_data (smp_data),
        .sw_en    (sw_en),
        .hit      (hit)
    );

    rail_hold_tmr #(.HOLD_TICKS(HOLD_TICKS)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .load (t_load),
        .dec  (t_dec),
        .clr  (t_clr),
        .last (last)
    );

    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_dec   = 1'b0;
        t_clr   = 1'b0;
        if (sw_en) begin
            if (!adapt) begin
                state_d = ST_FIXED;              // leave-adaptive
                t_clr   = 1'b1;
            end else begin
                unique case (state_q)
                    ST_FIXED: begin              // enter-adaptive
                        state_d = ST_AD_HI;
                        t_load  = 1'b1;
                    end
                    ST_AD_HI: begin
                        if (hit) begin           // retrigger
                            t_load = 1'b1;
                        end else begin
                            t_dec = 1'b1;
                            if (last) state_d = ST_AD_LO;  // expire
                        end
                    end
                    ST_AD_LO: begin
                        if (hit) begin           // boost
                            state_d = ST_AD_HI;
                            t_load  = 1'b1;
                        end
                    end
                    default: begin
                        state_d = ST_AD_HI;
                        t_load  = 1'b1;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_AD_HI;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rail_hi <= 1'b1;
        else if (sw_en) rail_hi <= (state_d == ST_AD_HI) ||
                                   (state_d == ST_FIXED && fixed_hi);
    end

    p_only_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_en |=> $stable(rail_hi));
    p_boost_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && adapt && hit) |=> rail_hi);
    p_fixed_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && !adapt) |=> rail_hi == $past(fixed_hi));
    p_hold_early_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && adapt && state_q == ST_AD_HI && !hit && !last) |=> rail_hi);
    p_enter_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && adapt && state_q == ST_FIXED) |=> rail_hi);
endmodule

// File: tb/test_rail_sel_ctrl.sv
module test_rail_sel_ctrl;
    localparam int W    = 8;
    localparam int THR  = 64;
    localparam int HOLD = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   mode = 2'b11;
    logic         fixed_hi = 1'b0;
    logic         smp_valid = 1'b0;
    logic [W-1:0] smp_data = '0;
    logic         sw_en = 1'b0;
    logic         rail_hi;

    int    n_chk = 0;
    int    n_err = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // behavioural reference state
    bit m_rail = 1'b1, m_pend = 1'b0, m_adapt = 1'b1;
    int m_quiet = 0;

    rail_sel_ctrl #(.W(W), .CLIP_LVL(THR), .SW_RATE_HZ(HOLD)) i_rail_sel_ctrl (
        .clk(clk), .rst_n(rst_n), .mode(mode), .fixed_hi(fixed_hi),
        .smp_valid(smp_valid), .smp_data(smp_data), .sw_en(sw_en), .rail_hi(rail_hi)
    );

    always #5 clk = ~clk;

    function automatic bit is_loud(bit v, logic [W-1:0] d);
        int s;
        s = $signed(d);
        if (s < 0) s = -s;
        return v && (s > THR);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rail = 1'b1; m_pend = 1'b0; m_adapt = 1'b1; m_quiet = 0;
        end else begin
            bit loud;
            loud = is_loud(smp_valid, smp_data);
            if (sw_en) begin
                if (mode != 2'b11) begin
                    m_adapt = 1'b0; m_rail = fixed_hi;
                end else if (!m_adapt) begin
                    m_adapt = 1'b1; m_quiet = 0; m_rail = 1'b1;
                end else if (m_pend || loud) begin
                    m_quiet = 0; m_rail = 1'b1;
                end else begin
                    m_quiet++;
                    if (m_quiet >= HOLD) m_rail = 1'b0;
                end
                m_pend = 1'b0;
            end else if (loud) begin
                m_pend = 1'b1;
            end
        end
    end

    task automatic chk(string req, bit act, bit exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s rail_hi=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // reference comparison on every cycle, away from the active edge
    always @(negedge clk) if (rst_n && !done) chk(cur_req, rail_hi, m_rail);

    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            sw_en = (div == 3);
            div = (div + 1) % 4;
        end
    end

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (!sw_en) @(posedge clk);
        end
        @(negedge clk);
    endtask

    task automatic send(int v, bit valid);
        @(negedge clk);
        smp_data = W'(v); smp_valid = valid;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_err++;
        $display("FAIL watchdog expired rail_hi=%0b expected=done", rail_hi);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", rail_hi, 1'b1);
        rst_n = 1'b1;
        cur_req = "R1";
        ticks(HOLD - 1);
        chk("R1", rail_hi, 1'b1);
        ticks(1);
        chk("R1", rail_hi, 1'b0);

        cur_req = "R3";
        send(64, 1'b1);  ticks(2); chk("R3", rail_hi, 1'b0);
        send(-64, 1'b1); ticks(2); chk("R3", rail_hi, 1'b0);
        send(65, 1'b1);  ticks(1); chk("R3", rail_hi, 1'b1);
        cur_req = "R5";
        ticks(HOLD - 1); chk("R5", rail_hi, 1'b1);
        ticks(1);        chk("R5", rail_hi, 1'b0);
        cur_req = "R3";
        send(-128, 1'b1); ticks(1); chk("R3", rail_hi, 1'b1);
        ticks(HOLD);     chk("R5", rail_hi, 1'b0);

        cur_req = "R8";
        @(negedge clk); smp_data = 8'd127; smp_valid = 1'b0;
        ticks(3); chk("R8", rail_hi, 1'b0);
        smp_data = 8'h80; ticks(1); chk("R8", rail_hi, 1'b0);

        cur_req = "R7";
        ticks(1);
        send(100, 1'b1);
        chk("R7", rail_hi, 1'b0);
        ticks(1); chk("R4", rail_hi, 1'b1);

        cur_req = "R6";
        for (int k = 0; k < 4; k++) begin
            ticks(HOLD - 2);
            send(-90, 1'b1);
            chk("R6", rail_hi, 1'b1);
        end
        ticks(HOLD + 1); chk("R6", rail_hi, 1'b0);

        cur_req = "R2";
        mode = 2'b00; fixed_hi = 1'b1; ticks(1); chk("R2", rail_hi, 1'b1);
        fixed_hi = 1'b0; ticks(1); chk("R2", rail_hi, 1'b0);
        mode = 2'b01; send(120, 1'b1); ticks(2); chk("R2", rail_hi, 1'b0);
        mode = 2'b10; fixed_hi = 1'b1; ticks(1); chk("R2", rail_hi, 1'b1);
        fixed_hi = 1'b0; ticks(1); chk("R2", rail_hi, 1'b0);

        cur_req = "R9";
        mode = 2'b11; ticks(1); chk("R9", rail_hi, 1'b1);
        ticks(HOLD - 1); chk("R9", rail_hi, 1'b1);
        ticks(1); chk("R9", rail_hi, 1'b0);

        ticks(1);
        finish_run();
    end
endmodule